// File: doc/BRIEF.md
# Integer Execute Unit with Immediate Extension

This block is the execute stage of a small 32-bit load-store integer core. Each cycle it receives two register operands, a 16-bit immediate field, a 5-bit shift count and a 4-bit operation code. It returns one 32-bit result. The operation set covers three-operand register forms, immediate forms, constant shifts and an upper-immediate constant builder.

The block extends the immediate itself. Add-immediate treats the field as a signed value. The logical immediates treat it as a raw bit pattern with zeros above it. Building a full 32-bit constant takes two operations: an upper-immediate load, then an OR-immediate into the same register.

Arithmetic wraps modulo 2^32 and never traps. A signed-overflow flag reports when the two's-complement result did not fit. By default the result, the flag and a valid bit are captured in one output register stage.

Top module: `int_exec_unit`

## Requirements
- R1: Operation code 0 returns src_a + src_b and code 1 returns src_a - src_b (first source minus second), both wrapping modulo 2^32.
- R2: Operation code 6 returns src_a plus the 16-bit immediate sign-extended to 32 bits, so 0x8000 adds -32768 and 0x7FFF adds 32767.
- R3: Codes 2, 3, 4 and 5 return the bitwise AND, OR, NOR and XOR of src_a and src_b. The NOR of an operand with zero is its bitwise complement.
- R4: Codes 7, 8 and 9 return the bitwise AND, OR and XOR of src_a with the immediate zero-extended to 32 bits. The upper 16 bits of an AND-immediate result are therefore zero.
- R5: Code 10 shifts src_a left and code 11 shifts src_a right (logical) by shamt, from 0 to 31 places. Vacated bits are zero, and a count of 0 returns src_a unchanged.
- R6: Code 12 places the immediate in bits 31..16 of the result and zeros in bits 15..0. An OR-immediate of that result with a second immediate forms the full 32-bit constant.
- R7: Codes 13, 14 and 15 are unassigned; this includes any attempted NOR-immediate. They return a result of zero with the overflow flag clear.
- R8: ovf is 1 exactly when an operation with code 0, 1 or 6 produces a signed two's-complement overflow. For every other code it is 0.
- R9: With the output register enabled, result and ovf load on the clock edge where in_valid is 1 and hold otherwise. result_valid equals in_valid from the previous edge.
- R10: A synchronous active-high reset clears result, ovf and result_valid on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and code are valid this cycle |
| op_sel | input | 4 | Operation code (encodings in R1 to R7) |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| imm16 | input | 16 | Immediate field |
| shamt | input | 5 | Constant shift count |
| result | output | 32 | Result |
| result_valid | output | 1 | Result corresponds to an accepted operation |
| ovf | output | 1 | Signed overflow of add, subtract or add-immediate |

## Verification
Embedded assertions check the following on every cycle:
- the valid pipeline and the hold of result when no operation is accepted;
- the reset clearing;
- a zero result for unassigned codes;
- the zero upper half of AND-immediate and the zero lower half of the upper-immediate load;
- unchanged data for a zero shift count and zero for equal-operand subtraction;
- overflow raised only by the three arithmetic codes.

Only the bench's reference model can show that each value is numerically right. That includes the sign-extension boundary at 0x8000 and 0x7FFF, shifts by 31, all-ones operands, and the two-step constant build. It also covers overflow in both directions and random mixes of codes with gaps in in_valid.

// File: rtl/exec_pkg.sv
package exec_pkg;

   localparam int XLEN   = 32;
   localparam int IMMLEN = 16;
   localparam int SHLEN  = 5;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_AND  = 4'd2,
      OP_OR   = 4'd3,
      OP_NOR  = 4'd4,
      OP_XOR  = 4'd5,
      OP_ADDI = 4'd6,
      OP_ANDI = 4'd7,
      OP_ORI  = 4'd8,
      OP_XORI = 4'd9,
      OP_SLL  = 4'd10,
      OP_SRL  = 4'd11,
      OP_LUI  = 4'd12,
      OP_RSV0 = 4'd13,
      OP_RSV1 = 4'd14,
      OP_RSV2 = 4'd15
   } op_e;

   typedef enum logic [1:0] {
      LF_AND = 2'd0,
      LF_OR  = 2'd1,
      LF_NOR = 2'd2,
      LF_XOR = 2'd3
   } logic_fn_e;

   typedef enum logic [2:0] {
      RS_ZERO  = 3'd0,
      RS_ARITH = 3'd1,
      RS_LOGIC = 3'd2,
      RS_SHIFT = 3'd3,
      RS_UPPER = 3'd4
   } res_src_e;

endpackage

// File: rtl/exec_imm_ext.sv
module exec_imm_ext #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16,
   parameter bit SIGNED = 1'b1
) (
   input  logic [IMM_W-1:0]  imm,
   output logic [DATA_W-1:0] ext
);
   localparam int PAD_W = DATA_W - IMM_W;

   if (IMM_W > DATA_W) begin : g_bad_width
      $error("exec_imm_ext: IMM_W exceeds DATA_W");
   end

   if (SIGNED) begin : g_sign
      assign ext = {{PAD_W{imm[IMM_W-1]}}, imm};
   end else begin : g_zero
      assign ext = {{PAD_W{1'b0}}, imm};
   end
endmodule

// File: rtl/exec_addsub.sv
module exec_addsub #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   output logic [DATA_W-1:0] sum,
   output logic              ovf
);
   localparam int MSB = DATA_W - 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("exec_addsub: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] b_eff;

   always_comb begin
      b_eff = sub ? ~b : b;
      sum   = a + b_eff + {{(DATA_W-1){1'b0}}, sub};
      ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
   end
endmodule

// File: rtl/exec_logic.sv
module exec_logic #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0]         a,
   input  logic [DATA_W-1:0]         b,
   input  exec_pkg::logic_fn_e       fn,
   output logic [DATA_W-1:0]         y
);
   import exec_pkg::*;

   always_comb begin
      unique case (fn)
         LF_AND:  y = a & b;
         LF_OR:   y = a | b;
         LF_NOR:  y = ~(a | b);
         LF_XOR:  y = a ^ b;
         default: y = '0;
      endcase
   end
endmodule

// File: rtl/exec_shifter.sv
module exec_shifter #(
   parameter int DATA_W  = 32,
   parameter int SHAMT_W = 5
) (
   input  logic [DATA_W-1:0]  a,
   input  logic [SHAMT_W-1:0] shamt,
   input  logic               right,
   output logic [DATA_W-1:0]  y
);
   if ((1 << SHAMT_W) != DATA_W) begin : g_bad_width
      $error("exec_shifter: DATA_W must equal 2**SHAMT_W");
   end

   logic [DATA_W-1:0] stage [SHAMT_W+1];

   assign stage[0] = a;

   for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
      localparam int DIST = 1 << k;
      always_comb begin
         if (!shamt[k])
            stage[k+1] = stage[k];
         else if (right)
            stage[k+1] = stage[k] >> DIST;
         else
            stage[k+1] = stage[k] << DIST;
      end
   end

   assign y = stage[SHAMT_W];
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
   parameter int DATA_W  = exec_pkg::XLEN,
   parameter int IMM_W   = exec_pkg::IMMLEN,
   parameter int SHAMT_W = exec_pkg::SHLEN,
   parameter bit REG_OUT = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   input  logic [3:0]         op_sel,
   input  logic [DATA_W-1:0]  src_a,
   input  logic [DATA_W-1:0]  src_b,
   input  logic [IMM_W-1:0]   imm16,
   input  logic [SHAMT_W-1:0] shamt,
   output logic [DATA_W-1:0]  result,
   output logic               result_valid,
   output logic               ovf
);
   import exec_pkg::*;

   localparam int LOW_W = DATA_W - IMM_W;

   if (IMM_W >= DATA_W) begin : g_bad_imm
      $error("int_exec_unit: IMM_W must be narrower than DATA_W");
   end
   if ((1 << SHAMT_W) != DATA_W) begin : g_bad_shamt
      $error("int_exec_unit: SHAMT_W must address every bit of DATA_W");
   end

   op_e op;
   assign op = op_e'(op_sel);

   logic [DATA_W-1:0] imm_sx, imm_zx;

   exec_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SIGNED(1'b1)) u_sx (
      .imm (imm16),
      .ext (imm_sx)
   );
   exec_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SIGNED(1'b0)) u_zx (
      .imm (imm16),
      .ext (imm_zx)
   );

   // Decode: operand B choice, unit controls and result source.
   logic [DATA_W-1:0] opnd_b;
   logic              do_sub, shr;
   logic_fn_e         lfn;
   res_src_e          rsrc;

   always_comb begin
      opnd_b = src_b;
      do_sub = 1'b0;
      shr    = 1'b0;
      lfn    = LF_AND;
      rsrc   = RS_ZERO;
      unique case (op)
         OP_ADD:  rsrc = RS_ARITH;
         OP_SUB:  begin rsrc = RS_ARITH; do_sub = 1'b1; end
         OP_ADDI: begin rsrc = RS_ARITH; opnd_b = imm_sx; end
         OP_AND:  begin rsrc = RS_LOGIC; lfn = LF_AND; end
         OP_OR:   begin rsrc = RS_LOGIC; lfn = LF_OR;  end
         OP_NOR:  begin rsrc = RS_LOGIC; lfn = LF_NOR; end
         OP_XOR:  begin rsrc = RS_LOGIC; lfn = LF_XOR; end
         OP_ANDI: begin rsrc = RS_LOGIC; lfn = LF_AND; opnd_b = imm_zx; end
         OP_ORI:  begin rsrc = RS_LOGIC; lfn = LF_OR;  opnd_b = imm_zx; end
         OP_XORI: begin rsrc = RS_LOGIC; lfn = LF_XOR; opnd_b = imm_zx; end
         OP_SLL:  rsrc = RS_SHIFT;
         OP_SRL:  begin rsrc = RS_SHIFT; shr = 1'b1; end
         OP_LUI:  rsrc = RS_UPPER;
         default: rsrc = RS_ZERO;
      endcase
   end

   logic [DATA_W-1:0] arith_y, logic_y, shift_y, upper_y;
   logic              arith_ovf;

   exec_addsub #(.DATA_W(DATA_W)) u_arith (
      .a   (src_a),
      .b   (opnd_b),
      .sub (do_sub),
      .sum (arith_y),
      .ovf (arith_ovf)
   );

   exec_logic #(.DATA_W(DATA_W)) u_logic (
      .a  (src_a),
      .b  (opnd_b),
      .fn (lfn),
      .y  (logic_y)
   );

   exec_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
      .a     (src_a),
      .shamt (shamt),
      .right (shr),
      .y     (shift_y)
   );

   assign upper_y = {imm16, {LOW_W{1'b0}}};

   logic [DATA_W-1:0] comb_res;
   logic              comb_ovf;

   always_comb begin
      comb_ovf = 1'b0;
      unique case (rsrc)
         RS_ARITH: begin comb_res = arith_y; comb_ovf = arith_ovf; end
         RS_LOGIC: comb_res = logic_y;
         RS_SHIFT: comb_res = shift_y;
         RS_UPPER: comb_res = upper_y;
         default:  comb_res = '0;
      endcase
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            result       <= '0;
            ovf          <= 1'b0;
            result_valid <= 1'b0;
         end else begin
            result_valid <= in_valid;
            if (in_valid) begin
               result <= comb_res;
               ovf    <= comb_ovf;
            end
         end
      end

      p_valid_follow_r9: assert property (@(posedge clk) disable iff (rst)
         in_valid |=> result_valid);
      p_valid_drop_r9: assert property (@(posedge clk) disable iff (rst)
         !in_valid |=> !result_valid);
      p_hold_r9: assert property (@(posedge clk) disable iff (rst)
         !in_valid |=> ($stable(result) && $stable(ovf)));
      p_reset_clear_r10: assert property (@(posedge clk)
         rst |=> (result == '0 && !ovf && !result_valid));
   end else begin : g_comb
      assign result       = comb_res;
      assign ovf          = comb_ovf;
      assign result_valid = in_valid;
   end

   p_unused_zero_r7: assert property (@(posedge clk) disable iff (rst)
      (op_sel >= 4'd13) |-> (comb_res == '0 && !comb_ovf));
   p_andi_upper_r4: assert property (@(posedge clk) disable iff (rst)
      (op == OP_ANDI) |-> (comb_res[DATA_W-1:IMM_W] == '0));
   p_lui_low_r6: assert property (@(posedge clk) disable iff (rst)
      (op == OP_LUI) |-> (comb_res[LOW_W-1:0] == '0));
   p_shift_zero_r5: assert property (@(posedge clk) disable iff (rst)
      ((op == OP_SLL || op == OP_SRL) && shamt == '0) |-> (comb_res == src_a));
   p_sub_self_r1: assert property (@(posedge clk) disable iff (rst)
      (op == OP_SUB && src_a == src_b) |-> (comb_res == '0));
   p_ovf_arith_r8: assert property (@(posedge clk) disable iff (rst)
      comb_ovf |-> (op == OP_ADD || op == OP_SUB || op == OP_ADDI));

endmodule

// File: tb/sim_int_exec_unit.sv
module sim_int_exec_unit;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [3:0]  op_sel;
   logic [31:0] src_a, src_b;
   logic [15:0] imm16;
   logic [4:0]  shamt;
   logic [31:0] result;
   logic        result_valid;
   logic        ovf;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 8 ns period, 125 MHz

   int_exec_unit u0 (
      .clk          (clk),
      .rst          (rst),
      .in_valid     (in_valid),
      .op_sel       (op_sel),
      .src_a        (src_a),
      .src_b        (src_b),
      .imm16        (imm16),
      .shamt        (shamt),
      .result       (result),
      .result_valid (result_valid),
      .ovf          (ovf)
   );

   // Expected outputs after the most recent edge
   logic [31:0] exp_res = '0;
   logic        exp_ovf = 1'b0;
   logic        exp_val = 1'b0;
   string       exp_tag = "R10";

   function automatic string req_of(input logic [3:0] op);
      case (op)
         4'd0, 4'd1:             return "R1";
         4'd6:                   return "R2";
         4'd2, 4'd3, 4'd4, 4'd5: return "R3";
         4'd7, 4'd8, 4'd9:       return "R4";
         4'd10, 4'd11:           return "R5";
         4'd12:                  return "R6";
         default:                return "R7";
      endcase
   endfunction

   // Behavioural reference: value and signed overflow
   task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] im, input logic [4:0] sh,
                        output logic [31:0] r, output logic o);
      longint sa, sb, wide;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      o  = 1'b0;
      r  = '0;
      case (op)
         4'd0: begin wide = sa + sb; r = a + b; end
         4'd1: begin wide = sa - sb; r = a - b; end
         4'd6: begin wide = sa + longint'($signed(im)); r = a + 32'($signed(im)); end
         default: wide = 0;
      endcase
      if (op == 4'd0 || op == 4'd1 || op == 4'd6)
         o = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
      case (op)
         4'd2:  r = a & b;
         4'd3:  r = a | b;
         4'd4:  r = ~(a | b);
         4'd5:  r = a ^ b;
         4'd7:  r = a & {16'h0000, im};
         4'd8:  r = a | {16'h0000, im};
         4'd9:  r = a ^ {16'h0000, im};
         4'd10: r = a << sh;
         4'd11: r = a >> sh;
         4'd12: r = {im, 16'h0000};
         default: ;
      endcase
   endtask

   task automatic compare();
      checks++;
      if (result !== exp_res || ovf !== exp_ovf) begin
         errors++;
         $display("FAIL %s result=%h ovf=%b expected result=%h ovf=%b",
                  exp_tag, result, ovf, exp_res, exp_ovf);
      end
      checks++;
      if (result_valid !== exp_val) begin
         errors++;
         $display("FAIL %s result_valid=%b expected %b",
                  (exp_tag == "R10") ? "R10" : "R9", result_valid, exp_val);
      end
   endtask

   // One cycle: check what the last edge produced, then drive the next inputs
   task automatic step(input logic r, input logic v, input logic [3:0] op,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic [4:0] sh);
      logic [31:0] mr;
      logic        mo;
      @(negedge clk);
      compare();
      rst = r; in_valid = v; op_sel = op; src_a = a; src_b = b; imm16 = im; shamt = sh;
      if (r) begin
         exp_res = '0; exp_ovf = 1'b0; exp_val = 1'b0; exp_tag = "R10";
      end else begin
         exp_val = v;
         if (v) begin
            model(op, a, b, im, sh, mr, mo);
            exp_res = mr; exp_ovf = mo; exp_tag = req_of(op);
         end else begin
            exp_tag = "R9";
         end
      end
   endtask

   task automatic op1(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic [15:0] im, input logic [4:0] sh);
      step(1'b0, 1'b1, op, a, b, im, sh);
   endtask

   initial begin
      rst = 1'b1; in_valid = 1'b0; op_sel = '0; src_a = '0; src_b = '0; imm16 = '0; shamt = '0;
      // R10: reset state
      step(1'b1, 1'b0, 4'd0, '0, '0, '0, '0);
      step(1'b1, 1'b1, 4'd0, 32'h5, 32'h6, '0, '0);

      // R1: add and subtract with wrap, operand order and overflow (R8)
      op1(4'd0, 32'd7, 32'd5, '0, '0);
      op1(4'd1, 32'd7, 32'd5, '0, '0);
      op1(4'd1, 32'd5, 32'd7, '0, '0);
      op1(4'd0, 32'hFFFF_FFFF, 32'h1, '0, '0);
      op1(4'd0, 32'h7FFF_FFFF, 32'h1, '0, '0);
      op1(4'd1, 32'h8000_0000, 32'h1, '0, '0);
      op1(4'd1, 32'h1234_5678, 32'h1234_5678, '0, '0);
      // R2: sign-extension boundary
      op1(4'd6, 32'd100, '0, 16'h8000, '0);
      op1(4'd6, 32'd100, '0, 16'h7FFF, '0);
      op1(4'd6, 32'h7FFF_FFFF, '0, 16'h0001, '0);
      op1(4'd6, 32'h8000_0000, '0, 16'hFFFF, '0);
      // R3: register logic, NOR with zero is NOT
      op1(4'd2, 32'hFFFF_FFFF, 32'h0F0F_1234, '0, '0);
      op1(4'd3, 32'hF000_000F, 32'h0000_FF00, '0, '0);
      op1(4'd4, 32'h1234_5678, 32'h0, '0, '0);
      op1(4'd5, 32'hFFFF_FFFF, 32'hA5A5_5A5A, '0, '0);
      // R4: zero-extended logical immediates
      op1(4'd7, 32'hFFFF_FFFF, '0, 16'h8FFF, '0);
      op1(4'd8, 32'h1234_0000, '0, 16'hFFFF, '0);
      op1(4'd9, 32'hFFFF_FFFF, '0, 16'h8000, '0);
      // R5: shift counts 0 and 31 and an all-ones operand
      op1(4'd10, 32'hFFFF_FFFF, '0, '0, 5'd0);
      op1(4'd10, 32'hFFFF_FFFF, '0, '0, 5'd31);
      op1(4'd11, 32'hFFFF_FFFF, '0, '0, 5'd31);
      op1(4'd11, 32'h8000_0000, '0, '0, 5'd0);
      op1(4'd11, 32'hF000_0000, '0, '0, 5'd4);
      // R6: upper-immediate then OR-immediate forms 0xAAAAF0F0
      op1(4'd12, 32'hFFFF_FFFF, '0, 16'hAAAA, '0);
      op1(4'd8, 32'hAAAA_0000, '0, 16'hF0F0, '0);
      // R7: unassigned codes return zero
      op1(4'd13, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd31);
      op1(4'd14, 32'h7FFF_FFFF, 32'h1, 16'h7FFF, 5'd1);
      op1(4'd15, 32'h8000_0000, 32'h8000_0000, 16'h8000, 5'd3);
      // R9: result holds while in_valid is low
      op1(4'd0, 32'd40, 32'd2, '0, '0);
      step(1'b0, 1'b0, 4'd5, 32'hDEAD_BEEF, 32'h1, '0, '0);
      step(1'b0, 1'b0, 4'd12, 32'h0, 32'h0, 16'h1234, '0);
      // R10: reset in mid-run clears a held result
      op1(4'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, '0, '0);
      step(1'b1, 1'b1, 4'd3, 32'hFFFF_FFFF, '0, '0, '0);

      // Random mix of codes, corner operands and valid gaps
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] a, b;
         logic [15:0] im;
         case ($urandom_range(0, 5))
            0: a = 32'hFFFF_FFFF;
            1: a = 32'h8000_0000;
            2: a = 32'h7FFF_FFFF;
            default: a = $urandom;
         endcase
         b  = ($urandom_range(0, 4) == 0) ? 32'hFFFF_FFFF : $urandom;
         case ($urandom_range(0, 3))
            0: im = 16'h8000;
            1: im = 16'h7FFF;
            default: im = 16'($urandom);
         endcase
         step(1'b0, ($urandom_range(0, 3) != 0), 4'($urandom_range(0, 15)), a, b, im,
              5'($urandom_range(0, 31)));
      end
      step(1'b0, 1'b0, '0, '0, '0, '0, '0);

      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule